// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed accumulator of twice the operand width, held as a high half and a low half. Each accepted operation multiplies two signed operands, sign-extends the product to the accumulator width and adds it to the signed concatenation of the two halves. The sum is then split back into the halves. A long operation multiplies the full operands. A word operation multiplies only the signed narrow fields in the low bits of each operand.

A saturation-mode input changes the result after the add, and its effect depends on the operation. For a long operation, the upper part of the high half is forced to follow the sign of the sum. For a word operation, a sum outside the signed single-half range is replaced by an overflow marker. That marker has the value 1 in the high half and the nearest signed bound in the low half. With saturation off, both operations keep the wrapped sum.

Software or a sequencer can clear the accumulator, load either half, and read both halves at any time.

Top module: `smac_unit`

## Requirements
- R1: After reset both accumulator halves read zero.
- R2: With acc_clr high, both halves are zero after the next clock edge. Clear takes priority over loads and over an operation in the same cycle.
- R3: With hi_load or lo_load high and acc_clr low, the selected half takes load_data at the next edge. Both halves load when both strobes are high. An operation strobed in the same cycle is ignored.
- R4: With no clear, no load and op_valid low, both halves hold their values.
- R5: With op_sel=0 (long) and sat_en=0, the halves become the 2W-bit wrapped sum of the signed accumulator and the signed W x W product of op_a and op_b.
- R6: With op_sel=1 (word) and sat_en=0, the halves become the 2W-bit wrapped sum of the signed accumulator and the signed product of op_a[N-1:0] and op_b[N-1:0]. Bits N and above of the operands have no effect.
- R7: With op_sel=0 and sat_en=1, the low half is the wrapped low half of the sum. If the sum is negative, the top W/2 bits of the high half are forced to ones. If it is non-negative, every high-half bit above bit W/2-2 is cleared.
- R8: With op_sel=1 and sat_en=1, a sum below -2^(W-1) leaves the high half equal to 1 and the low half equal to 2^(W-1).
- R9: With op_sel=1 and sat_en=1, a sum above 2^(W-1)-1 leaves the high half equal to 1 and the low half equal to 2^(W-1)-1. A sum within range, including both bounds, is kept unchanged.
- R10: Each op_valid cycle performs exactly one operation, and its result is visible on acc_hi and acc_lo right after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept one operation this cycle |
| op_sel | input | 1 | 0 = long (full operands), 1 = word (narrow low fields) |
| sat_en | input | 1 | Saturation mode for the accepted operation |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| acc_clr | input | 1 | Zero both halves |
| hi_load | input | 1 | Write load_data into the high half |
| lo_load | input | 1 | Write load_data into the low half |
| load_data | input | W | Data for the half loads |
| acc_hi | output | W | High half of the accumulator |
| acc_lo | output | W | Low half of the accumulator |

## Verification
The bench builds two instances with W=8 and N=4: one with the single shared multiplier and one with separate long and narrow multipliers. Both must match the same arithmetic model on every cycle. At this width, every word-mode operand pair is swept from several preloaded accumulator values, with random upper operand bits, in both saturation modes. The long-mode sweeps cover every op_a value against a strided set of op_b values. Directed sequences place the word-mode sum exactly on each signed bound and one step past it. They also exercise the priority among clear, load and operation.

// File: rtl/smac_pkg.sv
package smac_pkg;
   typedef enum logic {
      OP_LONG = 1'b0,
      OP_WORD = 1'b1
   } smac_op_e;
endpackage

// File: rtl/smac_prod.sv
module smac_prod #(
   parameter int W           = 32,
   parameter int N           = 16,
   parameter bit SHARED_MULT = 1'b1
) (
   input  smac_pkg::smac_op_e op_kind,
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   output logic [2*W-1:0]     prod
);
   import smac_pkg::*;

   localparam int PW = 2 * W;
   localparam int NW = 2 * N;

   if (N < 2 || N > W) begin : g_bad_n
      $error("smac_prod: N must lie in 2..W");
   end

   if (SHARED_MULT) begin : g_shared
      // One W x W multiplier; narrow fields are sign-extended in front of it.
      logic signed [W-1:0]  ma;
      logic signed [W-1:0]  mb;
      logic signed [PW-1:0] p;
      always_comb begin
         if (op_kind == OP_WORD) begin
            ma = {{(W-N){a[N-1]}}, a[N-1:0]};
            mb = {{(W-N){b[N-1]}}, b[N-1:0]};
         end else begin
            ma = a;
            mb = b;
         end
      end
      assign p    = ma * mb;
      assign prod = p;
   end else begin : g_split
      // Separate full and narrow multipliers, selected afterwards.
      logic signed [W-1:0]  fa;
      logic signed [W-1:0]  fb;
      logic signed [N-1:0]  na;
      logic signed [N-1:0]  nb;
      logic signed [PW-1:0] pf;
      logic signed [NW-1:0] pn;
      assign fa = a;
      assign fb = b;
      assign na = a[N-1:0];
      assign nb = b[N-1:0];
      assign pf = fa * fb;
      assign pn = na * nb;
      assign prod = (op_kind == OP_WORD) ? {{(PW-NW){pn[NW-1]}}, pn} : pf;
   end
endmodule

// File: rtl/smac_sat.sv
module smac_sat #(
   parameter int W = 32
) (
   input  smac_pkg::smac_op_e op_kind,
   input  logic               sat_en,
   input  logic [2*W-1:0]     sum,
   output logic [W-1:0]       nhi,
   output logic [W-1:0]       nlo
);
   import smac_pkg::*;

   localparam int PW = 2 * W;
   localparam int HB = W / 2;
   localparam logic [W-1:0] NEG_OR  = {{HB{1'b1}}, {(W-HB){1'b0}}};
   localparam logic [W-1:0] POS_AND = {{(W-HB+1){1'b0}}, {(HB-1){1'b1}}};
   localparam logic [W-1:0] ONE_HI  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] MIN_LO  = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_LO  = {1'b0, {(W-1){1'b1}}};

   logic word_under;
   logic word_over;

   // Outside the signed single-half range when the bits from W-1 upward
   // are not all copies of the sign.
   assign word_under = sum[PW-1] && !(&sum[PW-1:W-1]);
   assign word_over  = !sum[PW-1] && (|sum[PW-2:W-1]);

   always_comb begin
      nhi = sum[PW-1:W];
      nlo = sum[W-1:0];
      if (sat_en) begin
         if (op_kind == OP_LONG) begin
            if (sum[PW-1]) nhi = nhi | NEG_OR;
            else           nhi = nhi & POS_AND;
         end else begin
            if (word_under) begin
               nhi = ONE_HI;
               nlo = MIN_LO;
            end else if (word_over) begin
               nhi = ONE_HI;
               nlo = MAX_LO;
            end
         end
      end
   end
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
   parameter int W           = 32,
   parameter int N           = 16,
   parameter bit SHARED_MULT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic         op_sel,
   input  logic         sat_en,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         acc_clr,
   input  logic         hi_load,
   input  logic         lo_load,
   input  logic [W-1:0] load_data,
   output logic [W-1:0] acc_hi,
   output logic [W-1:0] acc_lo
);
   import smac_pkg::*;

   localparam int PW = 2 * W;
   localparam int HB = W / 2;
   localparam logic [W-1:0] ONE_HI = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] MIN_LO = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_LO = {1'b0, {(W-1){1'b1}}};

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("smac_unit: W must be even and at least 4");
   end

   smac_op_e       op_kind;
   logic [PW-1:0]  prod;
   logic [PW-1:0]  sum;
   logic [W-1:0]   nhi;
   logic [W-1:0]   nlo;
   logic           any_load;

   assign op_kind  = smac_op_e'(op_sel);
   assign any_load = hi_load | lo_load;

   smac_prod #(.W(W), .N(N), .SHARED_MULT(SHARED_MULT)) u_prod (
      .op_kind (op_kind),
      .a       (op_a),
      .b       (op_b),
      .prod    (prod)
   );

   assign sum = {acc_hi, acc_lo} + prod;

   smac_sat #(.W(W)) u_sat (
      .op_kind (op_kind),
      .sat_en  (sat_en),
      .sum     (sum),
      .nhi     (nhi),
      .nlo     (nlo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi <= '0;
         acc_lo <= '0;
      end else if (acc_clr) begin
         acc_hi <= '0;
         acc_lo <= '0;
      end else if (any_load) begin
         if (hi_load) acc_hi <= load_data;
         if (lo_load) acc_lo <= load_data;
      end else if (op_valid) begin
         acc_hi <= nhi;
         acc_lo <= nlo;
      end
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc_hi == '0 && acc_lo == '0)); // R2

   AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && hi_load) |=> (acc_hi == $past(load_data))); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && !any_load && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo))); // R4

   AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && !any_load && op_valid && !op_sel && sat_en)
      |=> ((&acc_hi[W-1:W-HB]) || (acc_hi[W-1:HB-1] == '0))); // R7

   AST_WORD_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && !any_load && op_valid && op_sel && sat_en)
      |=> (acc_hi == '0 || acc_hi == '1 || acc_hi == ONE_HI)); // R8

   AST_WORD_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && !any_load && op_valid && op_sel && sat_en)
      |=> (acc_hi != ONE_HI || acc_lo == MIN_LO || acc_lo == MAX_LO)); // R9
endmodule

// File: tb/smac_unit_tb.sv
module smac_unit_tb;
   localparam int W  = 8;
   localparam int N  = 4;
   localparam int PW = 2 * W;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic         op_sel = 1'b0;
   logic         sat_en = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         acc_clr = 1'b0;
   logic         hi_load = 1'b0;
   logic         lo_load = 1'b0;
   logic [W-1:0] load_data = '0;
   logic [W-1:0] acc_hi, acc_lo, acc_hi_s, acc_lo_s;

   int checks = 0;
   int errors = 0;
   logic [PW-1:0] m_acc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smac_unit #(.W(W), .N(N), .SHARED_MULT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .acc_clr(acc_clr),
      .hi_load(hi_load), .lo_load(lo_load), .load_data(load_data),
      .acc_hi(acc_hi), .acc_lo(acc_lo));

   smac_unit #(.W(W), .N(N), .SHARED_MULT(1'b1)) u_dut_sh (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .acc_clr(acc_clr),
      .hi_load(hi_load), .lo_load(lo_load), .load_data(load_data),
      .acc_hi(acc_hi_s), .acc_lo(acc_lo_s));

   function automatic longint sx(longint v, int bits);
      longint m = longint'(1) << bits;
      longint r = v & (m - 1);
      if (r >= m / 2) r = r - m;
      return r;
   endfunction

   function automatic logic [PW-1:0] model(logic [PW-1:0] acc, bit op, bit sat,
                                           logic [W-1:0] a, logic [W-1:0] b);
      longint cur = sx(longint'(acc), PW);
      longint prd = op ? sx(longint'(a), N) * sx(longint'(b), N)
                       : sx(longint'(a), W) * sx(longint'(b), W);
      longint res = sx(cur + prd, PW);
      longint hm  = (longint'(1) << W) - 1;
      longint rhi = (res >>> W) & hm;
      longint rlo = res & hm;
      longint lim = longint'(1) << (W - 1);
      if (sat) begin
         if (!op) begin
            if (res < 0) rhi = rhi | (hm & ~((longint'(1) << (W/2)) - 1));
            else         rhi = rhi & ((longint'(1) << (W/2 - 1)) - 1);
         end else if (res < -lim) begin
            rhi = 1; rlo = lim;
         end else if (res > lim - 1) begin
            rhi = 1; rlo = lim - 1;
         end
      end
      return {rhi[W-1:0], rlo[W-1:0]};
   endfunction

   task automatic chk(string tag);
      checks++;
      if (acc_hi !== m_acc[PW-1:W] || acc_lo !== m_acc[W-1:0] ||
          acc_hi_s !== m_acc[PW-1:W] || acc_lo_s !== m_acc[W-1:0]) begin
         errors++;
         $display("FAIL %s: hi/lo split %h/%h shared %h/%h expected %h/%h", tag,
                  acc_hi, acc_lo, acc_hi_s, acc_lo_s, m_acc[PW-1:W], m_acc[W-1:0]);
      end
   endtask

   // All tasks start and end right after a falling edge.
   task automatic do_op(string tag, bit op, bit sat, logic [W-1:0] a, logic [W-1:0] b);
      op_valid = 1'b1; op_sel = op; sat_en = sat; op_a = a; op_b = b;
      @(negedge clk);
      op_valid = 1'b0;
      m_acc = model(m_acc, op, sat, a, b);
      chk(tag);
   endtask

   task automatic preload(logic [W-1:0] hi, logic [W-1:0] lo);
      hi_load = 1'b1; load_data = hi;
      @(negedge clk);
      hi_load = 1'b0; lo_load = 1'b1; load_data = lo;
      @(negedge clk);
      lo_load = 1'b0;
      m_acc = {hi, lo};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      m_acc = '0;
      chk("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // R3 loads, one half then both halves together.
      hi_load = 1'b1; load_data = 8'h5A;
      @(negedge clk);
      hi_load = 1'b0;
      m_acc[PW-1:W] = 8'h5A;
      chk("R3 high load");
      hi_load = 1'b1; lo_load = 1'b1; load_data = 8'h3C;
      @(negedge clk);
      hi_load = 1'b0; lo_load = 1'b0;
      m_acc = {8'h3C, 8'h3C};
      chk("R3 both halves load");

      // R3 load beats an operation in the same cycle.
      lo_load = 1'b1; load_data = 8'h11;
      op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; op_a = 8'h7F; op_b = 8'h7F;
      @(negedge clk);
      lo_load = 1'b0; op_valid = 1'b0;
      m_acc[W-1:0] = 8'h11;
      chk("R3 load wins over operation");

      // R4 idle cycles with operands moving.
      op_a = 8'hFF; op_b = 8'h80;
      repeat (3) @(negedge clk);
      chk("R4 idle hold");

      // R2 clear beats load and operation.
      acc_clr = 1'b1; hi_load = 1'b1; load_data = 8'hEE; op_valid = 1'b1;
      @(negedge clk);
      acc_clr = 1'b0; hi_load = 1'b0; op_valid = 1'b0;
      m_acc = '0;
      chk("R2 clear priority");

      // R10 back-to-back strobes, one result per edge.
      do_op("R10 back-to-back first", 1'b0, 1'b0, 8'd3, 8'd5);
      do_op("R10 back-to-back second", 1'b0, 1'b0, 8'd3, 8'd5);

      // R5 long, saturation off.
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 7)
            do_op("R5 long wrap", 1'b0, 1'b0, a[W-1:0], b[W-1:0]);

      // R7 long, saturation on.
      preload(8'hC3, 8'h21);
      for (int a = 0; a < 256; a++)
         for (int b = 3; b < 256; b += 7)
            do_op("R7 long saturate", 1'b0, 1'b1, a[W-1:0], b[W-1:0]);

      // R6 word, saturation off; upper operand bits random.
      for (int p = 0; p < 4; p++) begin
         preload(8'(p * 67 + 5), 8'(p * 41 + 200));
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               do_op("R6 word wrap", 1'b1, 1'b0,
                     {4'($urandom), a[3:0]}, {4'($urandom), b[3:0]});
      end

      // R8/R9 word, saturation on, from in-range and out-of-range starts.
      for (int p = 0; p < 4; p++) begin
         preload((p % 2) ? 8'hFF : 8'h00, 8'(p * 90 + 7));
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               do_op("R8 R9 word saturate sweep", 1'b1, 1'b1,
                     {4'($urandom), a[3:0]}, {4'($urandom), b[3:0]});
      end

      // R9 exact upper bound kept, one past saturates.
      preload(8'h00, 8'h7F);
      do_op("R9 upper bound kept", 1'b1, 1'b1, 8'h00, 8'h05);
      do_op("R9 above bound to 1/7F", 1'b1, 1'b1, 8'h01, 8'h01);
      // R8 exact lower bound kept, one past saturates.
      preload(8'hFF, 8'h80);
      do_op("R8 lower bound kept", 1'b1, 1'b1, 8'h30, 8'h00);
      do_op("R8 below bound to 1/80", 1'b1, 1'b1, 8'h0F, 8'h01);
      // R6 upper operand bits ignored in word mode.
      preload(8'h00, 8'h00);
      do_op("R6 upper bits ignored", 1'b1, 1'b0, 8'hF3, 8'hA2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule